// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block drives an 8-bit raw NAND flash bus to program one page. A client pulses `start_i` together with a packed row/page address, the number of address cycles to send, a large-page flag, a column address and a small set of spare-area bytes. The sequencer captures all of these on the start cycle. It then issues the data-input command (0x80) and the address cycles, most significant byte first. For large pages it inserts a random-data-input command (0x85) with a two-byte column address. It then writes the spare bytes and issues the program-confirm command (0x10).

Once the confirm has gone out, the sequencer watches the ready/busy line. If the flash returns to ready within a programmable number of clock cycles, it sends read-status (0x70), pulls read-enable low and samples bit 0 of the status byte. It finishes with a one-cycle `done_o` or `fail_o` pulse. If the line stays busy too long, it gives up and pulses `tmo_o` without reading status.

Every bus step is held for `STEP_CYC` clock cycles, so one parameter sets the setup and hold margins around each write and read strobe. The default timeout of 1,000,000 cycles is about 20 ms at 50 MHz. `rb_i` and `dq_i` are assumed to be already synchronous to `clk`.

Top module: `nand_pgm_seq`

## Requirements
- R1: After reset, and whenever no operation is running, `ctl_o` is 4'b1010, `dq_oe_o` is 0, and `busy_o`, `done_o`, `fail_o` and `tmo_o` are all 0. The bits of `ctl_o` are ordered {RE#, ALE, WE#, CLE}.
- R2: A command cycle holds the command byte on `dq_o` with `dq_oe_o` high. During it, `ctl_o` steps through 1010, 1011, 1001, 1011, 1010.
- R3: Every step of the control vector lasts exactly `STEP_CYC` clock cycles, and `ctl_o` changes only at step boundaries.
- R4: An address phase of n cycles puts out 1110, then 1100 and 1110 for each byte, then a closing 1010, with `dq_oe_o` high throughout. Bytes are taken from the low n bytes of `addr_i`, highest byte first. `dq_o` carries the first byte during the leading step and the last byte during the closing step.
- R5: A requested address-cycle count of 0 is treated as 1, and a count above `MAX_ADDR` is treated as `MAX_ADDR`.
- R6: The write phase runs in this order: command 0x80, the row address, then 0x85 with two column bytes (`col_i[15:8]` then `col_i[7:0]`) only when `large_i` was set, then the spare bytes, then command 0x10.
- R7: Each spare byte k, taken from `spare_i[8k+7:8k]` starting at k = 0, is written as step 1000 followed by step 1010, with the byte on `dq_o`.
- R8: After 0x10, `ctl_o` sits at 1010 with `dq_oe_o` low until `rb_i` is sampled high. The next cycle begins command 0x70.
- R9: If `rb_i` stays low for `TMO_CYC` consecutive cycles after the confirm, `tmo_o` pulses and the block goes idle without a status read. A high `rb_i` on the last allowed cycle still counts as ready.
- R10: The status read holds 0010 with `dq_oe_o` low for one step and samples `dq_i[0]` at the end of that step. It then holds 1010 with `dq_oe_o` low for one step. After that, `done_o` pulses if the sampled bit was 0, and `fail_o` pulses if it was 1.
- R11: `done_o`, `fail_o` and `tmo_o` are single-cycle pulses, never more than one at a time. Each appears in the first idle cycle after the operation.
- R12: A `start_i` seen while busy is ignored. Changing any request input after the start cycle has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| addr_i | input | MAX_ADDR*8 | Packed address bytes, byte 0 in the low bits |
| acyc_i | input | clog2(MAX_ADDR+1) | Number of address cycles requested |
| large_i | input | 1 | Large-page flag, enables the 0x85 column path |
| col_i | input | 16 | Column address for the 0x85 path |
| spare_i | input | SPARE_N*8 | Spare bytes, byte 0 written first |
| rb_i | input | 1 | Ready/busy from the flash, 1 = ready |
| dq_i | input | 8 | Data bus input |
| dq_o | output | 8 | Data bus output |
| dq_oe_o | output | 1 | Data bus output enable |
| ctl_o | output | 4 | Control lines {RE#, ALE, WE#, CLE} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Program passed pulse |
| fail_o | output | 1 | Program failed pulse |
| tmo_o | output | 1 | Ready/busy timeout pulse |

## Verification
The bench compares every bus cycle against a step list built from the request. Random address counts from 1 to the maximum show whether byte ordering and the closing step track the count. Toggling the large-page flag shows whether the 0x85 column detour is inserted only when asked for, and counts of 0 and 7 separate the two clamping edges. Ready delays of 1 cycle and of exactly the timeout limit, a line that never goes ready, and status bytes with bit 0 set or clear tell apart pass, fail and timeout. Scrambling the inputs and pulsing start mid-operation shows that the request was captured once.

// File: rtl/nps_pkg.sv
// Shared types and constants for the NAND page program sequencer.
// Assumes the control vector order {RE#, ALE, WE#, CLE}.
package nps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_SPARE,
        ST_WAIT,
        ST_STAT
    } nps_state_e;

    typedef enum logic [1:0] {
        CM_PROG,
        CM_RAND,
        CM_CONF,
        CM_STAT
    } nps_cmd_e;

    localparam logic [3:0] CTL_IDLE = 4'b1010;

    // Map a command selector to the byte placed on the bus.
    function automatic logic [7:0] cmd_byte(input nps_cmd_e c);
        case (c)
            CM_PROG: cmd_byte = 8'h80;
            CM_RAND: cmd_byte = 8'h85;
            CM_CONF: cmd_byte = 8'h10;
            default: cmd_byte = 8'h70;
        endcase
    endfunction

endpackage

// File: rtl/nps_step_timer.sv
// Step timer: counts the cycles of the current control-vector step and
// flags the last one. Assumes STEP_CYC >= 1; cleared whenever run is low.
module nps_step_timer #(
    parameter int STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_end
);
    localparam int CW = $clog2(STEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Last cycle of a step when running and the count has reached the limit.
    always_comb step_end = run && (cnt_q == LAST);

    // Advance within a step, restart at each boundary or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!run || step_end) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST));

endmodule

// File: rtl/nps_rb_timer.sv
// Ready/busy timeout counter: while run is high it counts cycles and raises
// expired on the TMO_CYC-th one. Assumes TMO_CYC >= 1; cleared when run is low.
module nps_rb_timer #(
    parameter int TMO_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Flag the final allowed busy cycle.
    always_comb expired = run && (cnt_q == LAST);

    // Count busy cycles while waiting; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run || expired) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/nps_bus_decode.sv
// Bus decoder: turns the sequencer state, command and step index into the
// control vector, data byte and output enable. Purely combinational.
// Assumes ncyc is already clamped to 1..MAX_ADDR.
module nps_bus_decode
    import nps_pkg::*;
#(
    parameter int MAX_ADDR = 5,
    parameter int SPARE_N  = 4,
    parameter int SW       = 4,
    parameter int ACW      = 3
) (
    input  nps_state_e              state,
    input  nps_cmd_e                cmd,
    input  logic [SW-1:0]           step,
    input  logic                    col_ph,
    input  logic [ACW-1:0]          ncyc,
    input  logic [MAX_ADDR*8-1:0]   addr,
    input  logic [15:0]             col,
    input  logic [SPARE_N*8-1:0]    spare,
    output logic [3:0]              ctl,
    output logic [7:0]              dq,
    output logic                    oe
);
    // Select control pattern, bus byte and enable for the current step.
    always_comb begin
        int n;
        int bi;
        int pos;
        int k;
        n   = col_ph ? 2 : int'(ncyc);
        bi  = (step == '0) ? 0 : (int'(step) - 1) / 2;
        if (bi > n - 1) bi = n - 1;
        pos = n - 1 - bi;
        k   = int'(step) / 2;
        if (k > SPARE_N - 1) k = SPARE_N - 1;
        ctl = CTL_IDLE;
        dq  = 8'h00;
        oe  = 1'b0;
        case (state)
            ST_CMD: begin
                oe = 1'b1;
                dq = cmd_byte(cmd);
                case (step)
                    SW'(1):  ctl = 4'b1011;
                    SW'(2):  ctl = 4'b1001;
                    SW'(3):  ctl = 4'b1011;
                    default: ctl = 4'b1010;
                endcase
            end
            ST_ADDR: begin
                oe = 1'b1;
                if (col_ph) dq = (bi == 0) ? col[15:8] : col[7:0];
                else        dq = addr[pos*8 +: 8];
                if (step == '0)               ctl = 4'b1110;
                else if (int'(step) == 2*n+1) ctl = 4'b1010;
                else if (step[0])             ctl = 4'b1100;
                else                          ctl = 4'b1110;
            end
            ST_SPARE: begin
                oe  = 1'b1;
                dq  = spare[k*8 +: 8];
                ctl = step[0] ? 4'b1010 : 4'b1000;
            end
            ST_STAT: begin
                ctl = (step == '0) ? 4'b0010 : 4'b1010;
            end
            default: begin
                ctl = CTL_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/nand_pgm_seq.sv
// NAND page program sequencer top: captures a request, walks the command,
// address, spare-write, ready-wait and status-read phases, and reports the
// outcome with one-cycle pulses. Assumes rb_i and dq_i are synchronous to clk.
module nand_pgm_seq
    import nps_pkg::*;
#(
    parameter int MAX_ADDR = 5,
    parameter int SPARE_N  = 4,
    parameter int STEP_CYC = 4,
    parameter int TMO_CYC  = 1000000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [MAX_ADDR*8-1:0]         addr_i,
    input  logic [$clog2(MAX_ADDR+1)-1:0] acyc_i,
    input  logic                          large_i,
    input  logic [15:0]                   col_i,
    input  logic [SPARE_N*8-1:0]          spare_i,
    input  logic                          rb_i,
    input  logic [7:0]                    dq_i,
    output logic [7:0]                    dq_o,
    output logic                          dq_oe_o,
    output logic [3:0]                    ctl_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          fail_o,
    output logic                          tmo_o
);
    localparam int ACW     = $clog2(MAX_ADDR + 1);
    localparam int MAXSTEP = (2*MAX_ADDR + 2 > 2*SPARE_N) ? 2*MAX_ADDR + 2 : 2*SPARE_N;
    localparam int SW      = $clog2(MAXSTEP + 1);

    nps_state_e            state_q;
    nps_cmd_e              cmd_q;
    logic [SW-1:0]         step_q;
    logic                  col_ph_q;
    logic                  large_q;
    logic [ACW-1:0]        ncyc_q;
    logic [MAX_ADDR*8-1:0] addr_q;
    logic [15:0]           col_q;
    logic [SPARE_N*8-1:0]  spare_q;
    logic                  stat_q;
    logic                  done_q;
    logic                  fail_q;
    logic                  tmo_q;

    logic                  stp_end;
    logic                  rb_exp;
    logic [ACW-1:0]        ncyc_in;
    logic [SW-1:0]         addr_last;

    nps_step_timer #(.STEP_CYC(STEP_CYC)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((state_q != ST_IDLE) && (state_q != ST_WAIT)),
        .step_end (stp_end)
    );

    nps_rb_timer #(.TMO_CYC(TMO_CYC)) u_rbt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_WAIT),
        .expired (rb_exp)
    );

    nps_bus_decode #(
        .MAX_ADDR (MAX_ADDR),
        .SPARE_N  (SPARE_N),
        .SW       (SW),
        .ACW      (ACW)
    ) u_dec (
        .state  (state_q),
        .cmd    (cmd_q),
        .step   (step_q),
        .col_ph (col_ph_q),
        .ncyc   (ncyc_q),
        .addr   (addr_q),
        .col    (col_q),
        .spare  (spare_q),
        .ctl    (ctl_o),
        .dq     (dq_o),
        .oe     (dq_oe_o)
    );

    // Clamp the requested address-cycle count into 1..MAX_ADDR.
    always_comb begin
        if (acyc_i == '0)                  ncyc_in = ACW'(1);
        else if (acyc_i > ACW'(MAX_ADDR))  ncyc_in = ACW'(MAX_ADDR);
        else                               ncyc_in = acyc_i;
    end

    // Index of the closing step of the current address phase (2n+1).
    always_comb addr_last = col_ph_q ? SW'(5) : SW'({ncyc_q, 1'b1});

    // Phase sequencing, request capture, status sampling and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CM_PROG;
            step_q   <= '0;
            col_ph_q <= 1'b0;
            large_q  <= 1'b0;
            ncyc_q   <= ACW'(1);
            addr_q   <= '0;
            col_q    <= '0;
            spare_q  <= '0;
            stat_q   <= 1'b0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q   <= addr_i;
                        ncyc_q   <= ncyc_in;
                        large_q  <= large_i;
                        col_q    <= col_i;
                        spare_q  <= spare_i;
                        cmd_q    <= CM_PROG;
                        col_ph_q <= 1'b0;
                        step_q   <= '0;
                        state_q  <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (stp_end) begin
                        if (step_q == SW'(4)) begin
                            step_q <= '0;
                            case (cmd_q)
                                CM_PROG: begin state_q <= ST_ADDR; col_ph_q <= 1'b0; end
                                CM_RAND: begin state_q <= ST_ADDR; col_ph_q <= 1'b1; end
                                CM_CONF: state_q <= ST_WAIT;
                                default: state_q <= ST_STAT;
                            endcase
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (stp_end) begin
                        if (step_q == addr_last) begin
                            step_q <= '0;
                            if (!col_ph_q && large_q) begin
                                state_q <= ST_CMD;
                                cmd_q   <= CM_RAND;
                            end else begin
                                state_q <= ST_SPARE;
                            end
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                ST_SPARE: begin
                    if (stp_end) begin
                        if (step_q == SW'(2*SPARE_N - 1)) begin
                            step_q  <= '0;
                            state_q <= ST_CMD;
                            cmd_q   <= CM_CONF;
                        end else begin
                            step_q <= step_q + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (rb_i) begin
                        state_q <= ST_CMD;
                        cmd_q   <= CM_STAT;
                        step_q  <= '0;
                    end else if (rb_exp) begin
                        state_q <= ST_IDLE;
                        tmo_q   <= 1'b1;
                    end
                end
                ST_STAT: begin
                    if (stp_end) begin
                        if (step_q == '0) begin
                            stat_q <= dq_i[0];
                            step_q <= SW'(1);
                        end else begin
                            state_q <= ST_IDLE;
                            step_q  <= '0;
                            done_q  <= !stat_q;
                            fail_q  <= stat_q;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the status outputs from state and the pulse registers.
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = done_q;
        fail_o = fail_q;
        tmo_o  = tmo_q;
    end

    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ctl_o == CTL_IDLE && !dq_oe_o));

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_o[3] == 1'b0 && ctl_o[1] == 1'b0) && !(ctl_o[2] && ctl_o[0]));

    assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != ST_WAIT && !stp_end) |=> $stable(ctl_o));

    assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (ctl_o == CTL_IDLE && !dq_oe_o));

    assert_tmo_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> $past(state_q == ST_WAIT && !rb_i));

    assert_read_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_o[3] |-> !dq_oe_o);

    assert_pulses_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, tmo_o}));

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || tmo_o) |=> !(done_o || fail_o || tmo_o));

    assert_start_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

endmodule

// File: tb/nand_pgm_seq_test.sv
module nand_pgm_seq_test;
    localparam int MAXA = 5;
    localparam int SPN  = 4;
    localparam int STEP = 2;
    localparam int TMO  = 40;
    localparam int ACW  = 3;
    localparam int AW   = MAXA * 8;
    localparam int SPW  = SPN * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [AW-1:0]   addr_i = '0;
    logic [ACW-1:0]  acyc_i = '0;
    logic            large_i = 1'b0;
    logic [15:0]     col_i = '0;
    logic [SPW-1:0]  spare_i = '0;
    logic            rb_i = 1'b0;
    logic [7:0]      dq_i = '0;
    logic [7:0]      dq_o;
    logic            dq_oe_o;
    logic [3:0]      ctl_o;
    logic            busy_o, done_o, fail_o, tmo_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [3:0] ec [0:63];
    logic [7:0] ed [0:63];
    int ns;

    nand_pgm_seq #(.MAX_ADDR(MAXA), .SPARE_N(SPN), .STEP_CYC(STEP), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .acyc_i(acyc_i),
        .large_i(large_i), .col_i(col_i), .spare_i(spare_i), .rb_i(rb_i), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o), .ctl_o(ctl_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .tmo_o(tmo_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [7:0] d);
        ec[ns] = c;
        ed[ns] = d;
        ns++;
    endtask

    task automatic push_cmd(input logic [7:0] c);
        push(4'b1010, c); push(4'b1011, c); push(4'b1001, c); push(4'b1011, c); push(4'b1010, c);
    endtask

    task automatic scramble();
        addr_i  = AW'({$urandom(), $urandom()});
        acyc_i  = ACW'($urandom());
        large_i = 1'($urandom());
        col_i   = 16'($urandom());
        spare_i = SPW'($urandom());
    endtask

    // One full operation; w == 0 means the flash never becomes ready.
    task automatic run(input logic [AW-1:0] a, input logic [ACW-1:0] n, input logic lg,
                       input logic [15:0] col, input logic [SPW-1:0] sp,
                       input int w, input logic [7:0] st);
        int ne;
        bit ok;
        logic [31:0] fa, fe;
        ne = (n == 0) ? 1 : ((int'(n) > MAXA) ? MAXA : int'(n));
        ns = 0;
        push_cmd(8'h80);
        push(4'b1110, a[(ne-1)*8 +: 8]);
        for (int b = 0; b < ne; b++) begin
            push(4'b1100, a[(ne-1-b)*8 +: 8]);
            push(4'b1110, a[(ne-1-b)*8 +: 8]);
        end
        push(4'b1010, a[7:0]);
        if (lg) begin
            push_cmd(8'h85);
            push(4'b1110, col[15:8]);
            push(4'b1100, col[15:8]); push(4'b1110, col[15:8]);
            push(4'b1100, col[7:0]);  push(4'b1110, col[7:0]);
            push(4'b1010, col[7:0]);
        end
        for (int k = 0; k < SPN; k++) begin
            push(4'b1000, sp[k*8 +: 8]);
            push(4'b1010, sp[k*8 +: 8]);
        end
        push_cmd(8'h10);

        @(negedge clk);
        addr_i = a; acyc_i = n; large_i = lg; col_i = col; spare_i = sp;
        rb_i = 1'b0; dq_i = st; start_i = 1'b1;
        ok = 1; fa = 0; fe = 0;
        for (int k = 0; k < ns*STEP; k++) begin
            @(negedge clk);
            if (ok && (ctl_o !== ec[k/STEP] || dq_oe_o !== 1'b1 || dq_o !== ed[k/STEP] || busy_o !== 1'b1
                       || done_o || fail_o || tmo_o)) begin
                ok = 0;
                fa = {8'(k), 3'b0, dq_oe_o, ctl_o, dq_o, 8'h0};
                fe = {8'(k), 3'b0, 1'b1, ec[k/STEP], ed[k/STEP], 8'h0};
            end
            if (k == 0) begin
                start_i = 1'b0;
                scramble();
            end
        end
        chk(ok, "R2/R3/R4/R5/R6/R7/R12 write phase", fa, fe);

        ok = 1; fa = 0; fe = 0;
        if (w == 0) begin
            for (int i = 0; i < TMO; i++) begin
                @(negedge clk);
                if (ok && (ctl_o !== 4'b1010 || dq_oe_o !== 1'b0 || busy_o !== 1'b1 || tmo_o)) begin
                    ok = 0; fa = {27'(i), ctl_o, dq_oe_o}; fe = {27'(i), 4'b1010, 1'b0};
                end
            end
            chk(ok, "R8 wait phase", fa, fe);
            @(negedge clk);
            chk(tmo_o === 1'b1 && !done_o && !fail_o && !busy_o, "R9 timeout pulse",
                {tmo_o, done_o, fail_o, busy_o}, 4'b1000);
            @(negedge clk);
            chk(!tmo_o && ctl_o === 4'b1010 && !busy_o, "R9/R11 after timeout",
                {tmo_o, ctl_o, busy_o}, {1'b0, 4'b1010, 1'b0});
            return;
        end
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (ok && (ctl_o !== 4'b1010 || dq_oe_o !== 1'b0 || busy_o !== 1'b1 || tmo_o)) begin
                ok = 0; fa = {27'(i), ctl_o, dq_oe_o}; fe = {27'(i), 4'b1010, 1'b0};
            end
            if (i == 0 && w >= 3) begin start_i = 1'b1; scramble(); end
            if (i == 1) start_i = 1'b0;
            if (i == w-1) rb_i = 1'b1;
        end
        chk(ok, "R8 wait phase", fa, fe);

        ok = 1; fa = 0; fe = 0;
        for (int k = 0; k < 7*STEP; k++) begin
            logic [3:0] xc;
            logic xo;
            int s;
            s = k / STEP;
            if (s < 5) begin
                xo = 1'b1;
                xc = (s == 1 || s == 3) ? 4'b1011 : (s == 2) ? 4'b1001 : 4'b1010;
            end else begin
                xo = 1'b0;
                xc = (s == 5) ? 4'b0010 : 4'b1010;
            end
            @(negedge clk);
            if (ok && (ctl_o !== xc || dq_oe_o !== xo || (xo && dq_o !== 8'h70) || !busy_o)) begin
                ok = 0; fa = {8'(k), dq_oe_o, ctl_o, dq_o}; fe = {8'(k), xo, xc, 8'h70};
            end
        end
        chk(ok, "R8/R10 status read", fa, fe);
        @(negedge clk);
        rb_i = 1'b0;
        chk(done_o === !st[0] && fail_o === st[0] && !tmo_o && !busy_o, "R10/R11 result pulse",
            {done_o, fail_o, tmo_o, busy_o}, {!st[0], st[0], 2'b00});
        @(negedge clk);
        chk(!done_o && !fail_o && !tmo_o && ctl_o === 4'b1010 && !dq_oe_o, "R1/R11 pulse cleared",
            {done_o, fail_o, tmo_o, ctl_o, dq_oe_o}, {3'b000, 4'b1010, 1'b0});
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_o === 4'b1010 && !dq_oe_o && !busy_o && !done_o && !fail_o && !tmo_o,
            "R1 reset state", {ctl_o, dq_oe_o, busy_o, done_o, fail_o, tmo_o},
            {4'b1010, 5'b00000});

        // Directed corners
        run(40'h11_22_33_44_55, 3'd3, 1'b0, 16'hA1B2, 32'hDEADBEEF, 5, 8'h00);
        run(40'h11_22_33_44_55, 3'd0, 1'b0, 16'h0000, 32'h01020304, 1, 8'h00); // R5 low clamp
        run(40'h9A_BC_DE_F0_12, 3'd7, 1'b1, 16'h3C5A, 32'hCAFEF00D, 4, 8'h01); // R5 high clamp, fail
        run(40'h01_02_03_04_05, 3'd5, 1'b1, 16'h8510, 32'h10101010, TMO, 8'hFE); // ready at limit
        run(40'h01_02_03_04_05, 3'd2, 1'b0, 16'h0000, 32'h55AA55AA, 0, 8'h00);  // R9 timeout
        run(40'h77_66_55_44_33, 3'd4, 1'b1, 16'hFFFF, 32'h00000000, 0, 8'h00);  // timeout, large

        // Random runs
        for (int r = 0; r < 20; r++) begin
            run(AW'({$urandom(), $urandom()}), ACW'(1 + ($urandom() % MAXA)), 1'($urandom()),
                16'($urandom()), SPW'($urandom()), 1 + int'($urandom() % TMO), 8'($urandom()));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule